// File: doc/BRIEF.md
# Clock Source Selector with Loss-of-Clock Fallback

This block picks the system clock from three sources: an always-running internal RC oscillator, an external oscillator (roughly 4 to 26 MHz) and a PLL output. It leaves reset on the internal oscillator. Software asks for a source through a two-bit select input. The switch uses a handshake: the old source's gate is closed and acknowledged before the new gate opens. This keeps short or clipped pulses off the output clock.

While the external oscillator is in use, directly or as the PLL reference, a loss monitor counts internal-clock cycles since the last external edge. If the count reaches a programmable timeout, the controller forces the external and PLL gates shut and falls back to the internal oscillator. It also sets a sticky failure flag and, when enabled, raises an interrupt. The external and PLL sources stay locked out until software clears the flag. The status output always shows the source that last confirmed its gate, which can differ from the one requested.

The controller runs on the internal clock. Its states are `ST_RUN` (the confirmed source drives the output), `ST_DROP` (the old gate is closing), `ST_RAISE` (the new gate is opening) and `ST_RESCUE` (forced fallback after a failure). The transitions are:
- RUN→DROP when the accepted request differs from the current source.
- DROP→RAISE once the old gate's acknowledge is low.
- RAISE→RUN once the new gate's acknowledge is high.
- Any state→RESCUE on a detected failure.
- RESCUE→RUN once only the internal gate is acknowledged.

Reset enters `ST_RAISE` with the internal oscillator as target.

Top module: `clk_sel_failover`

## Requirements
- R1: After reset the output runs from the internal oscillator, `src_status` is 00, and `fail_flag` and `irq` are 0.
- R2: The `sel_req` encoding is 00 internal, 01 external, 10 PLL, and `src_status` uses the same encoding. After a request, the output runs at the chosen source's frequency and `src_status` shows it.
- R3: With `mon_en` high and the external oscillator in use, a failure is declared only after `timeout` internal cycles pass with no external edge. No failure is declared while external edges keep arriving, and none is declared before the timeout elapses.
- R4: On a failure, the output returns to the internal oscillator without software action, and `src_status` becomes 00.
- R5: `fail_flag` is set on a failure and stays set until a one-cycle pulse on `fail_clr`.
- R6: `irq` is high only while `fail_flag` is set and `irq_en` is high.
- R7: While `fail_flag` is set, requests for 01 or 10 are ignored. After the flag is cleared, a standing request takes effect.
- R8: A request of 11 is ignored, and the current source keeps driving the output.
- R9: With `pll_ref_ext` high, the PLL source counts as fed by the external oscillator. It is monitored and falls back in the same way as R3 to R5.
- R10: With `mon_en` low, no failure is declared even if the external clock stops. Raising `mon_en` later detects the stopped clock.
- R11: Switching is glitch-free. The output has no high or low phase shorter than the shortest source half period, and at most one gate is enabled or acknowledged at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal RC oscillator clock; also clocks the controller |
| clk_ext | input | 1 | External oscillator clock |
| clk_pll | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_req | input | 2 | Requested source (00 int, 01 ext, 10 PLL, 11 ignored) |
| pll_ref_ext | input | 1 | High when the PLL is referenced to the external oscillator |
| mon_en | input | 1 | Enables loss-of-clock monitoring |
| irq_en | input | 1 | Enables the failure interrupt |
| fail_clr | input | 1 | One-cycle pulse that clears the failure flag |
| timeout | input | CNT_W | Internal-clock cycles without an external edge before a failure is declared |
| clk_out | output | 1 | Selected system clock |
| src_status | output | 2 | Source actually driving `clk_out` |
| fail_flag | output | 1 | Sticky loss-of-clock flag |
| irq | output | 1 | Failure interrupt |

## Verification
The assertions check the following on every internal-clock cycle:
- at most one gate request and one gate acknowledge are active;
- the status code is never 11;
- a failure is never flagged without monitoring enabled;
- a settled controller with the flag set reports the internal source and cannot leave it.

Only the bench scenarios can show the rest. These include the output frequency seen for each source, the timeout window around a stopped oscillator, recovery after a flag clear, the PLL-referenced fallback, and the minimum pulse widths on the output clock across all switches.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_INT = 2'b00,
        SRC_EXT = 2'b01,
        SRC_PLL = 2'b10,
        SRC_BAD = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DROP   = 2'd1,
        ST_RAISE  = 2'd2,
        ST_RESCUE = 2'd3
    } fsm_state_e;

    function automatic logic [NUM_SRC-1:0] src_bit(src_e s);
        return NUM_SRC'(1) << s;
    endfunction

    function automatic logic needs_ext(src_e s, logic pll_on_ext);
        return (s == SRC_EXT) || ((s == SRC_PLL) && pll_on_ext);
    endfunction

endpackage

// File: rtl/clksel_gate.sv
`timescale 1ns/1ps
module clksel_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic force_off,
    input  logic en_req,
    output logic clk_gated,
    output logic en_live
);
    logic                   clr_n;
    logic [SYNC_STAGES-1:0] en_sh;

    assign clr_n = rst_n & ~force_off;

    // Enable moves only while the source clock is low, so the AND gate never clips a phase.
    always_ff @(negedge clk_src or negedge clr_n) begin
        if (!clr_n) begin
            en_sh <= '0;
        end else begin
            en_sh <= {en_sh[SYNC_STAGES-2:0], en_req};
        end
    end

    assign en_live   = en_sh[SYNC_STAGES-1];
    assign clk_gated = clk_src & en_live;
endmodule

// File: rtl/clksel_lossmon.sv
`timescale 1ns/1ps
module clksel_lossmon #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_int,
    input  logic             clk_ext,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] timeout,
    output logic             fail_det
);
    logic                 tog;
    logic [SYNC_STAGES:0] tsync;
    logic                 ext_edge;
    logic [CNT_W-1:0]     gap_cnt;

    always_ff @(posedge clk_ext or negedge rst_n) begin
        if (!rst_n) tog <= 1'b0;
        else        tog <= ~tog;
    end

    always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n) tsync <= '0;
        else        tsync <= {tsync[SYNC_STAGES-1:0], tog};
    end

    assign ext_edge = tsync[SYNC_STAGES] ^ tsync[SYNC_STAGES-1];

    always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (!active || ext_edge) begin
            gap_cnt <= '0;
        end else if (gap_cnt != '1) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign fail_det = active && !ext_edge && (timeout != '0) && (gap_cnt >= timeout);
endmodule

// File: rtl/clksel_fsm.sv
`timescale 1ns/1ps
module clksel_fsm
    import clksel_pkg::*;
(
    input  logic               clk_int,
    input  logic               rst_n,
    input  logic [1:0]         sel_req,
    input  logic               fail_det,
    input  logic               fail_clr,
    input  logic [NUM_SRC-1:0] gate_ack,
    output logic [NUM_SRC-1:0] en_req,
    output logic               force_off,
    output src_e               cur_src,
    output src_e               tgt_src,
    output logic               fail_flag,
    output fsm_state_e         state
);
    fsm_state_e         state_d;
    src_e               cur_d, tgt_d, want_q;
    logic [NUM_SRC-1:0] en_d;
    logic               force_d;
    logic               sel_ok;

    assign sel_ok = (sel_req != SRC_BAD) && ((sel_req == SRC_INT) || !fail_flag);

    // State register
    always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RAISE;
            cur_src   <= SRC_INT;
            tgt_src   <= SRC_INT;
            en_req    <= src_bit(SRC_INT);
            force_off <= 1'b0;
        end else begin
            state     <= state_d;
            cur_src   <= cur_d;
            tgt_src   <= tgt_d;
            en_req    <= en_d;
            force_off <= force_d;
        end
    end

    // Accepted request and sticky failure flag
    always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n) begin
            want_q    <= SRC_INT;
            fail_flag <= 1'b0;
        end else begin
            if (fail_det)    want_q <= SRC_INT;
            else if (sel_ok) want_q <= src_e'(sel_req);
            if (fail_det)      fail_flag <= 1'b1;
            else if (fail_clr) fail_flag <= 1'b0;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state;
        cur_d   = cur_src;
        tgt_d   = tgt_src;
        en_d    = en_req;
        force_d = force_off;
        if (fail_det) begin
            state_d = ST_RESCUE;
            tgt_d   = SRC_INT;
            en_d    = src_bit(SRC_INT);
            force_d = 1'b1;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (want_q != cur_src) begin
                        tgt_d   = want_q;
                        en_d    = en_req & ~src_bit(cur_src);
                        state_d = ST_DROP;
                    end
                end
                ST_DROP: begin
                    if ((gate_ack & src_bit(cur_src)) == '0) begin
                        en_d    = src_bit(tgt_src);
                        state_d = ST_RAISE;
                    end
                end
                ST_RAISE: begin
                    if ((gate_ack & src_bit(tgt_src)) != '0) begin
                        cur_d   = tgt_src;
                        state_d = ST_RUN;
                    end
                end
                ST_RESCUE: begin
                    if (gate_ack == src_bit(SRC_INT)) begin
                        cur_d   = SRC_INT;
                        force_d = 1'b0;
                        state_d = ST_RUN;
                    end
                end
                default: state_d = ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/clk_sel_failover.sv
`timescale 1ns/1ps
module clk_sel_failover
    import clksel_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_int,
    input  logic             clk_ext,
    input  logic             clk_pll,
    input  logic             rst_n,
    input  logic [1:0]       sel_req,
    input  logic             pll_ref_ext,
    input  logic             mon_en,
    input  logic             irq_en,
    input  logic             fail_clr,
    input  logic [CNT_W-1:0] timeout,
    output logic             clk_out,
    output logic [1:0]       src_status,
    output logic             fail_flag,
    output logic             irq
);
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] gated;
    logic [NUM_SRC-1:0] gate_live;
    logic [NUM_SRC-1:0] gate_ack;
    logic [NUM_SRC-1:0] gate_force;
    logic [NUM_SRC-1:0] en_req;
    logic               force_off;
    logic               fail_det;
    logic               mon_active;
    src_e               cur_src, tgt_src;
    fsm_state_e         fsm_state;

    assign src_clk = {clk_pll, clk_ext, clk_int};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [SYNC_STAGES-1:0] ack_sh;

        assign gate_force[i] = (i == int'(SRC_INT)) ? 1'b0 : force_off;

        clksel_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_src  (src_clk[i]),
            .rst_n    (rst_n),
            .force_off(gate_force[i]),
            .en_req   (en_req[i]),
            .clk_gated(gated[i]),
            .en_live  (gate_live[i])
        );

        always_ff @(posedge clk_int or negedge rst_n) begin
            if (!rst_n) ack_sh <= '0;
            else        ack_sh <= {ack_sh[SYNC_STAGES-2:0], gate_live[i]};
        end
        assign gate_ack[i] = ack_sh[SYNC_STAGES-1];
    end

    assign mon_active = mon_en && !fail_flag && (fsm_state != ST_RESCUE) &&
                        (needs_ext(cur_src, pll_ref_ext) || needs_ext(tgt_src, pll_ref_ext));

    clksel_lossmon #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk_int (clk_int),
        .clk_ext (clk_ext),
        .rst_n   (rst_n),
        .active  (mon_active),
        .timeout (timeout),
        .fail_det(fail_det)
    );

    clksel_fsm u_fsm (
        .clk_int  (clk_int),
        .rst_n    (rst_n),
        .sel_req  (sel_req),
        .fail_det (fail_det),
        .fail_clr (fail_clr),
        .gate_ack (gate_ack),
        .en_req   (en_req),
        .force_off(force_off),
        .cur_src  (cur_src),
        .tgt_src  (tgt_src),
        .fail_flag(fail_flag),
        .state    (fsm_state)
    );

    assign clk_out    = |gated;
    assign src_status = cur_src;
    assign irq        = fail_flag & irq_en;
endmodule

// File: rtl/clksel_checker.sv
`timescale 1ns/1ps
module clksel_checker
    import clksel_pkg::*;
(
    input logic               clk_int,
    input logic               rst_n,
    input logic               mon_en,
    input logic               fail_flag,
    input logic [1:0]         src_status,
    input fsm_state_e         fsm_state,
    input logic [NUM_SRC-1:0] gate_ack,
    input logic [NUM_SRC-1:0] en_req
);
    a_r2_status_legal: assert property (@(posedge clk_int) disable iff (!rst_n)
        src_status != 2'b11);

    a_r3_fail_needs_monitor: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(fail_flag) |-> $past(mon_en));

    a_r5_settled_fallback: assert property (@(posedge clk_int) disable iff (!rst_n)
        (fail_flag && fsm_state == ST_RUN) |-> src_status == SRC_INT);

    a_r7_locked_on_int: assert property (@(posedge clk_int) disable iff (!rst_n)
        (fail_flag && src_status == SRC_INT) |=> src_status == SRC_INT);

    a_r11_one_ack: assert property (@(posedge clk_int) disable iff (!rst_n)
        $onehot0(gate_ack));

    a_r11_one_req: assert property (@(posedge clk_int) disable iff (!rst_n)
        $onehot0(en_req));
endmodule

bind clk_sel_failover clksel_checker u_chk (
    .clk_int   (clk_int),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .fail_flag (fail_flag),
    .src_status(src_status),
    .fsm_state (fsm_state),
    .gate_ack  (gate_ack),
    .en_req    (en_req)
);

// File: tb/clk_sel_failover_bench.sv
`timescale 1ns/1ps
module clk_sel_failover_bench;
    localparam int CNT_W = 8;

    logic clk_int = 1'b0;
    logic clk_ext = 1'b0;
    logic clk_pll = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sel_req = 2'b00;
    logic pll_ref_ext = 1'b0;
    logic mon_en = 1'b0;
    logic irq_en = 1'b0;
    logic fail_clr = 1'b0;
    logic [CNT_W-1:0] timeout = 8'd20;
    logic clk_out;
    logic [1:0] src_status;
    logic fail_flag;
    logic irq;

    logic ext_run = 1'b1;
    int errors = 0;
    int checks = 0;
    int edge_cnt = 0;
    bit finished = 1'b0;
    bit meas_on = 1'b0;
    realtime last_rise = 0.0, last_fall = 0.0;
    realtime min_hi = 1000.0, min_lo = 1000.0;

    typedef struct {
        string req;
        int    st;
        int    fl;
        int    iq;
        int    edges;
    } exp_t;
    exp_t sb_q[$];

    clk_sel_failover #(.CNT_W(CNT_W)) u_clk_sel_failover (
        .clk_int(clk_int), .clk_ext(clk_ext), .clk_pll(clk_pll), .rst_n(rst_n),
        .sel_req(sel_req), .pll_ref_ext(pll_ref_ext), .mon_en(mon_en),
        .irq_en(irq_en), .fail_clr(fail_clr), .timeout(timeout),
        .clk_out(clk_out), .src_status(src_status), .fail_flag(fail_flag), .irq(irq)
    );

    always #4 clk_int = ~clk_int;

    initial forever begin
        #10;
        if (ext_run) clk_ext = ~clk_ext;
        else         clk_ext = 1'b0;
    end

    initial forever begin
        #5;
        if (!pll_ref_ext || ext_run) clk_pll = ~clk_pll;
        else                         clk_pll = 1'b0;
    end

    always @(posedge clk_out) begin
        edge_cnt++;
        if (meas_on && ($realtime - last_fall) < min_lo) min_lo = $realtime - last_fall;
        last_rise = $realtime;
    end

    always @(negedge clk_out) begin
        if (meas_on && ($realtime - last_rise) < min_hi) min_hi = $realtime - last_rise;
        last_fall = $realtime;
    end

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares against the ports
    initial forever begin
        exp_t e;
        int   s0, got;
        wait (sb_q.size() > 0);
        e = sb_q[0];
        @(negedge clk_int);
        if (e.edges >= 0) begin
            s0 = edge_cnt;
            repeat (50) @(negedge clk_int);
            got = edge_cnt - s0;
            checks++;
            if (got < e.edges - 1 || got > e.edges + 1) begin
                errors++;
                $display("FAIL %s clk_out edges: actual=%0d expected=%0d", e.req, got, e.edges);
            end
        end
        check_val(e.req, "src_status", int'(src_status), e.st);
        check_val(e.req, "fail_flag", int'(fail_flag), e.fl);
        check_val(e.req, "irq", int'(irq), e.iq);
        void'(sb_q.pop_front());
    end

    // Driver side: push an expected item and wait for the monitor to consume it
    task automatic expect_now(string req, int st, int fl, int iq, int edges);
        exp_t e;
        e.req = req; e.st = st; e.fl = fl; e.iq = iq; e.edges = edges;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk_int);
    endtask

    task automatic pulse_clear();
        @(negedge clk_int); fail_clr = 1'b1;
        @(negedge clk_int); fail_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_int);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cycles(10);
        rst_n = 1'b1;
        cycles(20);
        meas_on = 1'b1;
        // R1: reset state, internal clock at 8 ns -> 50 edges in 400 ns
        expect_now("R1", 0, 0, 0, 50);

        // R2: external source (20 ns period -> 20 edges)
        sel_req = 2'b01; cycles(30);
        expect_now("R2", 1, 0, 0, 20);

        // R8: invalid code keeps external
        sel_req = 2'b11; cycles(30);
        expect_now("R8", 1, 0, 0, 20);

        // R2: PLL source (10 ns period -> 40 edges)
        sel_req = 2'b10; cycles(30);
        expect_now("R2", 2, 0, 0, 40);

        // R3: monitor on with running external clock: no false alarm
        sel_req = 2'b01; mon_en = 1'b1; cycles(80);
        expect_now("R3", 1, 0, 0, 20);

        // R3: stopped clock not flagged before the timeout
        ext_run = 1'b0; cycles(10);
        expect_now("R3", 1, 0, 0, -1);

        // R4/R5: fallback to internal, flag set, irq masked (R6)
        cycles(50);
        expect_now("R4", 0, 1, 0, 50);
        expect_now("R5", 0, 1, 0, -1);

        // R6: irq follows the enable
        irq_en = 1'b1; cycles(2);
        expect_now("R6", 0, 1, 1, -1);

        // R7: lock-out while flagged
        sel_req = 2'b10; cycles(40);
        expect_now("R7", 0, 1, 1, 50);

        // R7: clear lets the standing request through
        ext_run = 1'b1; cycles(5);
        pulse_clear(); cycles(40);
        expect_now("R7", 2, 0, 0, 40);

        // R9: PLL fed by external clock that stops
        pll_ref_ext = 1'b1; ext_run = 1'b0; cycles(60);
        expect_now("R9", 0, 1, 1, 50);

        // Recover on internal
        ext_run = 1'b1; pll_ref_ext = 1'b0; sel_req = 2'b00; cycles(5);
        pulse_clear(); cycles(40);
        expect_now("R5", 0, 0, 0, 50);

        // R10: monitor off, external stops: no failure, output stalls
        mon_en = 1'b0; sel_req = 2'b01; cycles(40);
        ext_run = 1'b0; cycles(40);
        expect_now("R10", 1, 0, 0, 0);

        // R10: enabling the monitor later catches the dead clock
        mon_en = 1'b1; cycles(60);
        expect_now("R10", 0, 1, 1, 50);

        // R11: no runt phases anywhere on clk_out
        checks++;
        if (min_hi < 3.9) begin
            errors++;
            $display("FAIL R11 min high phase: actual=%0.2f expected>=4.00", min_hi);
        end
        checks++;
        if (min_lo < 3.9) begin
            errors++;
            $display("FAIL R11 min low phase: actual=%0.2f expected>=4.00", min_lo);
        end

        finish_run();
    end
endmodule